// File: doc/BRIEF.md
# Two-Wire Configuration Slave

This block is a fast-mode two-wire serial slave that lives inside a clock-control subsystem. It oversamples the serial clock and data lines with the system clock and decodes START, repeated START and STOP conditions. It acknowledges its own 7-bit device address and answers on the open-drain data line by pulling it low. Behind it sits a small bank of seven configuration bytes. The contents of that bank are driven out in parallel to the clock-control logic.

A transfer opens with the address and a write bit, followed by a command byte. The top bit of the command byte must be set. Its low seven bits select the first byte offset. Each data byte that follows is written at the current offset, and the offset then advances, so a two-byte write fills the offset and the byte after it. To read, the master issues a repeated START with the read bit. The slave then returns bytes from the offset, advancing after each one. A master ACK asks for another byte and a master NACK ends the read.

The upper five address bits are a parameter, and the two low bits come from strap inputs, so four copies can share one bus. Byte 0 holds a read-only identity value.

Top module: `twi_cfg_slave`

## Requirements
- R1: The slave ACKs an address byte whose upper seven bits equal 11010 followed by strap_i[1:0], and whose bit 0 selects write (0) or read (1). For any other address it gives no ACK and ignores the bus until the next START.
- R2: The slave ACKs a command byte with bit 7 set and takes bits 6:0 as the byte offset. A command byte with bit 7 clear gets no ACK, and the rest of the transfer is ignored.
- R3: In a write transfer, each data byte is ACKed and stored at the current offset. The result appears on cfg_o[8*k+7:8*k] for offset k.
- R4: After each data byte written, the offset advances by one, so the second byte of a word write lands at offset+1.
- R5: After a repeated START with the read bit, the slave shifts out the byte at the offset MSB first and then advances the offset. A master ACK makes it send the next byte; a master NACK ends the read.
- R6: Out of reset, bytes 0 to 6 are 0xC3 (the identity parameter), 0x20, 0x30, 0x00, 0x30, 0xFF and 0xF0, and sda_oe_o is 0.
- R7: Byte 0 and bit 6 of byte 5 are read-only. Writes to them are ACKed and leave those bits unchanged; the write mask of byte 5 is 0xBF.
- R8: Writes to offsets 7 and above are ACKed and change nothing. Reads from those offsets return 0x00.
- R9: A STOP or START before the falling SCL edge that ends a byte's eighth bit discards that byte. Bytes completed earlier stay written.
- R10: sda_oe_o goes high only while the filtered SCL is low. It is released on STOP, and START and STOP are never seen together.
- R11: A low pulse on SCL lasting fewer than three system-clock samples is filtered out and does not count as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least about 20x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 2 | Pin-strapped low address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| cfg_o | output | 56 | Configuration bytes, byte k on bits 8k+7:8k |

## Verification
The bench aims at the partial-byte abort: it sends four bits after a completed byte and then a STOP. A design that stores bits as they arrive would corrupt the next register. Wrong addresses and commands with bit 7 clear are each followed by further bytes. A slave that resumed listening would ACK those bytes and write one of them. Writes to read-only bits and to offset 7 are checked at cfg_o, and a read that runs past offset 6 must return 0x00. A two-sample low glitch is placed in the middle of a data bit; without the filter the design would count an extra bit and store a shifted value.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;

   localparam int unsigned OFF_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDATA,
      ST_ACK,
      ST_TX,
      ST_MACK
   } bus_state_t;

   // bits a write may change in each byte
   function automatic logic [7:0] reg_wmask(input int unsigned idx);
      case (idx)
         0:       return 8'h00;
         5:       return 8'hBF;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] reg_init(input int unsigned idx, input logic [7:0] id_val);
      case (idx)
         0:       return id_val;
         1:       return 8'h20;
         2:       return 8'h30;
         3:       return 8'h00;
         4:       return 8'h30;
         5:       return 8'hFF;
         6:       return 8'hF0;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3,
   parameter logic        IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twi_line_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("twi_line_filter: FILT_LEN must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [FILT_LEN-1:0]    hist_q;
   logic                   all_hi;
   logic                   all_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
         hist_q <= {FILT_LEN{IDLE_LEVEL}};
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      end
   end

   assign all_hi = &hist_q;
   assign all_lo = ~|hist_q;

   // output moves only once every sample in the window agrees
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      line_o <= IDLE_LEVEL;
      else if (all_hi) line_o <= 1'b1;
      else if (all_lo) line_o <= 1'b0;
   end

endmodule

// File: rtl/twi_cfg_regs.sv
module twi_cfg_regs
   import twi_cfg_pkg::*;
#(
   parameter int unsigned NUM_REGS = 7,
   parameter logic [7:0]  ID_VALUE = 8'hC3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [OFF_W-1:0]      wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [OFF_W-1:0]      rd_addr,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] WMASK = reg_wmask(g);
      localparam logic [7:0] RVAL  = reg_init(g, ID_VALUE);
      logic [7:0] q;

      if (WMASK == 8'h00) begin : g_ro
         assign q = RVAL;
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RVAL;
            else if (wr_en && wr_addr == OFF_W'(g))
               q <= (q & ~WMASK) | (wr_data & WMASK);
         end
      end

      assign cfg_o[g*8 +: 8] = q;
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == OFF_W'(i)) rd_data = cfg_o[i*8 +: 8];
      end
   end

endmodule

// File: rtl/twi_bus_fsm.sv
module twi_bus_fsm
   import twi_cfg_pkg::*;
#(
   parameter int unsigned    HI_W    = 5,
   parameter int unsigned    STRAP_W = 2,
   parameter logic [HI_W-1:0] DEV_HI = 5'b11010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_f,
   input  logic               sda_f,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [7:0]         rd_data,
   output logic [OFF_W-1:0]   ptr_o,
   output logic               wr_en,
   output logic [OFF_W-1:0]   wr_addr,
   output logic [7:0]         wr_data,
   output logic               sda_oe,
   output logic               start_det,
   output logic               stop_det
);

   localparam int unsigned ADDR_W = HI_W + STRAP_W;
   if (ADDR_W != 7) begin : g_bad_addr
      $error("twi_bus_fsm: device address must be 7 bits");
   end

   bus_state_t       st_q;
   bus_state_t       after_ack_q;
   logic             scl_q;
   logic             sda_q;
   logic [3:0]       bit_cnt_q;
   logic [7:0]       shreg_q;
   logic [7:0]       txb_q;
   logic             mack_q;
   logic [OFF_W-1:0] ptr_q;
   logic             scl_rise;
   logic             scl_fall;
   logic             addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
   assign addr_hit  = (shreg_q[7:1] == {DEV_HI, strap_i});
   assign ptr_o     = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         after_ack_q <= ST_IDLE;
         bit_cnt_q   <= '0;
         shreg_q     <= '0;
         txb_q       <= '0;
         mack_q      <= 1'b0;
         ptr_q       <= '0;
         sda_oe      <= 1'b0;
         wr_en       <= 1'b0;
         wr_addr     <= '0;
         wr_data     <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st_q      <= ST_ADDR;
            bit_cnt_q <= '0;
            sda_oe    <= 1'b0;
         end else if (stop_det) begin
            st_q   <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st_q)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (scl_rise && bit_cnt_q != 4'd8) begin
                     shreg_q   <= {shreg_q[6:0], sda_f};
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (scl_fall && bit_cnt_q == 4'd8) begin
                     bit_cnt_q <= '0;
                     if (st_q == ST_ADDR) begin
                        if (addr_hit) begin
                           sda_oe      <= 1'b1;
                           st_q        <= ST_ACK;
                           after_ack_q <= shreg_q[0] ? ST_TX : ST_CMD;
                        end else begin
                           st_q <= ST_IDLE;
                        end
                     end else if (st_q == ST_CMD) begin
                        if (shreg_q[7]) begin
                           ptr_q       <= shreg_q[6:0];
                           sda_oe      <= 1'b1;
                           st_q        <= ST_ACK;
                           after_ack_q <= ST_WDATA;
                        end else begin
                           st_q <= ST_IDLE;
                        end
                     end else begin
                        wr_en       <= 1'b1;
                        wr_addr     <= ptr_q;
                        wr_data     <= shreg_q;
                        ptr_q       <= ptr_q + 1'b1;
                        sda_oe      <= 1'b1;
                        st_q        <= ST_ACK;
                        after_ack_q <= ST_WDATA;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt_q <= '0;
                     st_q      <= after_ack_q;
                     if (after_ack_q == ST_TX) begin
                        txb_q  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr_q  <= ptr_q + 1'b1;
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt_q == 4'd7) begin
                        sda_oe    <= 1'b0;
                        bit_cnt_q <= '0;
                        st_q      <= ST_MACK;
                     end else begin
                        txb_q     <= {txb_q[6:0], 1'b0};
                        sda_oe    <= ~txb_q[6];
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack_q <= ~sda_f;
                  if (scl_fall) begin
                     if (mack_q) begin
                        st_q   <= ST_TX;
                        txb_q  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr_q  <= ptr_q + 1'b1;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
   import twi_cfg_pkg::*;
#(
   parameter int unsigned     NUM_REGS    = 7,
   parameter logic [7:0]      ID_VALUE    = 8'hC3,
   parameter int unsigned     HI_W        = 5,
   parameter int unsigned     STRAP_W     = 2,
   parameter logic [HI_W-1:0] DEV_HI      = 5'b11010,
   parameter int unsigned     SYNC_STAGES = 2,
   parameter int unsigned     FILT_LEN    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic [STRAP_W-1:0]    strap_i,
   output logic                  sda_oe_o,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   localparam int unsigned NUM_LINES = 2;

   if (NUM_REGS < 1 || NUM_REGS > (1 << OFF_W)) begin : g_bad_regs
      $error("twi_cfg_slave: NUM_REGS out of range");
   end

   logic [NUM_LINES-1:0] raw_lines;
   logic [NUM_LINES-1:0] filt_lines;
   logic                 scl_f;
   logic                 sda_f;
   logic [OFF_W-1:0]     ptr;
   logic [7:0]           rd_data;
   logic                 wr_en;
   logic [OFF_W-1:0]     wr_addr;
   logic [7:0]           wr_data;
   logic                 start_det;
   logic                 stop_det;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
      twi_line_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN),
         .IDLE_LEVEL (1'b1)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_lines[g]),
         .line_o(filt_lines[g])
      );
   end

   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   twi_bus_fsm #(
      .HI_W   (HI_W),
      .STRAP_W(STRAP_W),
      .DEV_HI (DEV_HI)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_f),
      .sda_f    (sda_f),
      .strap_i  (strap_i),
      .rd_data  (rd_data),
      .ptr_o    (ptr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sda_oe   (sda_oe_o),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   twi_cfg_regs #(
      .NUM_REGS(NUM_REGS),
      .ID_VALUE(ID_VALUE)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(ptr),
      .rd_data(rd_data),
      .cfg_o  (cfg_o)
   );

endmodule

// File: rtl/twi_cfg_checker.sv
module twi_cfg_checker #(
   parameter int unsigned NUM_REGS = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_f,
   input logic                  sda_oe_o,
   input logic                  start_det,
   input logic                  stop_det,
   input logic                  wr_en,
   input logic [6:0]            wr_addr,
   input logic [NUM_REGS*8-1:0] cfg_o
);

   p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_f);

   p_cond_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, stop_det}));

   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (32'(wr_addr) < NUM_REGS)) |=> $stable(cfg_o));

   p_range_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (32'(wr_addr) >= NUM_REGS)) |=> $stable(cfg_o));

   p_id_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cfg_o[7:0] == $past(cfg_o[7:0])));

endmodule

bind twi_cfg_slave twi_cfg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_f),
   .sda_oe_o (sda_oe_o),
   .start_det(start_det),
   .stop_det (stop_det),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .cfg_o    (cfg_o)
);

// File: tb/tb_twi_cfg_slave.sv
module tb_twi_cfg_slave;

   localparam int   NREG  = 7;
   localparam int   Q     = 25;
   localparam logic [4:0] DEV_HI = 5'b11010;
   localparam logic [1:0] STRAP  = 2'b01;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_oe;
   logic [NREG*8-1:0] cfg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct { logic [7:0] d; string tag; } item_t;
   item_t exp_q[$];
   item_t act_q[$];

   logic [7:0] mdl [NREG];

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   twi_cfg_slave dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_m),
      .sda_i   (sda_line),
      .strap_i (STRAP),
      .sda_oe_o(sda_oe),
      .cfg_o   (cfg)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int i = 0; i < NREG; i++) chk(tag, 32'(cfg[i*8 +: 8]), 32'(mdl[i]));
   endtask

   // write masks from R7: byte 0 none, byte 5 0xBF
   function automatic logic [7:0] wmask(input int idx);
      if (idx == 0) return 8'h00;
      if (idx == 5) return 8'hBF;
      return 8'hFF;
   endfunction

   function automatic void model_wr(input int idx, input logic [7:0] d);
      if (idx < NREG) mdl[idx] = (mdl[idx] & ~wmask(idx)) | (d & wmask(idx));
   endfunction

   function automatic logic [7:0] model_rd(input int idx);
      if (idx < NREG) return mdl[idx];
      return 8'h00;
   endfunction

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = (sda_line == 1'b0); wq(); scl_m = 1'b0; wq();
   endtask

   // bit 3 carries a 2-sample low glitch during its high phase
   task automatic send_byte_glitch(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         if (i == 3) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq();
            scl_m = 1'b0; repeat (2) @(negedge clk); scl_m = 1'b1;
            wq(); scl_m = 1'b0; wq();
         end else begin
            send_bit(b[i]);
         end
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = (sda_line == 1'b0); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
      end
      send_bit(~m_ack);
   endtask

   task automatic do_write(input logic [7:0] cmd, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input string tag);
      logic ack;
      bus_start();
      send_byte({DEV_HI, STRAP, 1'b0}, ack); chk({tag, " R1 addr ack"}, 32'(ack), 1);
      send_byte(cmd, ack);                   chk({tag, " R2 cmd ack"}, 32'(ack), 1);
      send_byte(d0, ack);                    chk({tag, " R3 data ack"}, 32'(ack), 1);
      model_wr(int'(cmd[6:0]), d0);
      if (n == 2) begin
         send_byte(d1, ack);                 chk({tag, " R4 second ack"}, 32'(ack), 1);
         model_wr(int'(cmd[6:0]) + 1, d1);
      end
      bus_stop();
      repeat (10) @(negedge clk);
      chk({tag, " R10 released"}, 32'(sda_oe), 0);
      chk_all(tag);
   endtask

   task automatic do_read(input logic [7:0] cmd, input int n, input string tag);
      logic ack;
      logic [7:0] b;
      item_t it;
      bus_start();
      send_byte({DEV_HI, STRAP, 1'b0}, ack); chk({tag, " R1 addr ack"}, 32'(ack), 1);
      send_byte(cmd, ack);                   chk({tag, " R2 cmd ack"}, 32'(ack), 1);
      bus_rstart();
      send_byte({DEV_HI, STRAP, 1'b1}, ack); chk({tag, " R1 raddr ack"}, 32'(ack), 1);
      for (int k = 0; k < n; k++) begin
         it.d = model_rd(int'(cmd[6:0]) + k); it.tag = tag; exp_q.push_back(it);
         recv_byte(k < n - 1, b);
         it.d = b; act_q.push_back(it);
      end
      bus_stop();
      repeat (10) @(negedge clk);
      chk({tag, " R10 released"}, 32'(sda_oe), 0);
   endtask

   // scoreboard monitor
   initial begin
      item_t a;
      item_t e;
      forever begin
         @(negedge clk);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            a = act_q.pop_front();
            e = exp_q.pop_front();
            checks++;
            if (a.d !== e.d) begin
               fails++;
               $display("FAIL %s read data actual %h expected %h", e.tag, a.d, e.d);
            end
         end
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic ack;
      mdl[0] = 8'hC3; mdl[1] = 8'h20; mdl[2] = 8'h30; mdl[3] = 8'h00;
      mdl[4] = 8'h30; mdl[5] = 8'hFF; mdl[6] = 8'hF0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk_all("R6 reset");
      chk("R6 oe reset", 32'(sda_oe), 0);

      do_write(8'h82, 1, 8'hA5, 8'h00, "R3 byte write");
      do_write(8'h83, 2, 8'h11, 8'h22, "R4 word write");
      do_read(8'h82, 1, "R5 byte read");
      do_read(8'h83, 2, "R5 word read");

      // R1 wrong strap bits, then bytes that must be ignored
      bus_start();
      send_byte({DEV_HI, 2'b10, 1'b0}, ack); chk("R1 strap mismatch nack", 32'(ack), 0);
      send_byte(8'h81, ack);                 chk("R1 ignored cmd", 32'(ack), 0);
      send_byte(8'h00, ack);                 chk("R1 ignored data", 32'(ack), 0);
      bus_stop();
      bus_start();
      send_byte({5'b10010, STRAP, 1'b0}, ack); chk("R1 upper mismatch nack", 32'(ack), 0);
      bus_stop();
      repeat (10) @(negedge clk);
      chk_all("R1 no change");

      // R2 command without top bit
      bus_start();
      send_byte({DEV_HI, STRAP, 1'b0}, ack); chk("R2 addr ack", 32'(ack), 1);
      send_byte(8'h01, ack);                 chk("R2 bad cmd nack", 32'(ack), 0);
      send_byte(8'h77, ack);                 chk("R2 data after bad cmd", 32'(ack), 0);
      bus_stop();
      repeat (10) @(negedge clk);
      chk_all("R2 no change");

      do_write(8'h80, 1, 8'h5A, 8'h00, "R7 id byte");
      do_write(8'h85, 1, 8'h00, 8'h00, "R7 byte5 bit6");
      chk("R7 byte5 value", 32'(cfg[47:40]), 32'h40);
      do_read(8'h85, 1, "R7 byte5 read");

      do_write(8'h87, 1, 8'h55, 8'h00, "R8 high offset");
      do_read(8'h86, 2, "R8 read past end");

      // R9 abort partway through a byte
      bus_start();
      send_byte({DEV_HI, STRAP, 1'b0}, ack); chk("R9 addr ack", 32'(ack), 1);
      send_byte(8'h81, ack);                 chk("R9 cmd ack", 32'(ack), 1);
      send_byte(8'h3C, ack);                 chk("R9 first data ack", 32'(ack), 1);
      model_wr(1, 8'h3C);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
      bus_stop();
      repeat (10) @(negedge clk);
      chk("R9 completed byte kept", 32'(cfg[15:8]), 32'h3C);
      chk("R9 partial byte dropped", 32'(cfg[23:16]), 32'(mdl[2]));
      chk_all("R9 bank");

      // R11 glitch inside a data bit
      bus_start();
      send_byte({DEV_HI, STRAP, 1'b0}, ack); chk("R11 addr ack", 32'(ack), 1);
      send_byte(8'h83, ack);                 chk("R11 cmd ack", 32'(ack), 1);
      send_byte_glitch(8'h6B, ack);          chk("R11 data ack", 32'(ack), 1);
      model_wr(3, 8'h6B);
      bus_stop();
      repeat (10) @(negedge clk);
      chk("R11 glitch filtered", 32'(cfg[31:24]), 32'h6B);

      do_read(8'h80, 3, "R5 three byte read");

      repeat (20) @(negedge clk);
      chk("R5 scoreboard drained", 32'(exp_q.size() + act_q.size()), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule